// File: doc/BRIEF.md
# Event-to-counter mapping table

This block sits beside the programmable counters of a small performance monitoring unit and records which counter follows which hardware event. Software programs it one counter at a time by writing a 20-bit event index for a chosen counter number. The block checks the counter number, then decides whether the write adds a new mapping, leaves an earlier one in place, removes mappings, or fails. The response comes back in the same cycle and the table changes on the next clock edge.

Event sources look up an event index and get a hit flag and a counter number back, with no clock delay. A second query port answers, for any counter number, whether that counter is counting clock cycles or retired instructions. Counters 0 and 2 are fixed to those two events. Every other counter counts them only while it holds the matching mapping. The counters themselves, privilege filtering and overflow interrupts are outside this block.

Top module: `evmap_table`

## Requirements
- R1: After reset the table holds no mappings, so every lookup gives lk_hit = 0 and lk_ctr = 0.
- R2: An event index is 20 bits: type in bits 19:16, code in bits 15:0. Keys compare on all 20 bits, so 0x00019 (type 0) is a different event from 0x10019 (type 1).
- R3: Only 0x00001 (cycles), 0x00002 (instructions), 0x10019 (data TLB read miss), 0x1001B (data TLB write miss) and 0x10021 (instruction TLB miss) can be mapped. A non-zero write of any other value to a valid counter raises wr_err and leaves the table unchanged.
- R4: Valid counters are those set in an availability mask with NUM_PROG ones starting at bit 3, which gives 3..10 by default. If NUM_PROG exceeds MAX_CTRS-3 the mask is empty. A write to any other counter number raises wr_err and changes nothing, even when the value is zero.
- R5: An accepted write of an unmapped whitelisted event maps it to wr_ctr. From the next cycle, a lookup of that event hits with that counter.
- R6: A write of an event that is already mapped to any counter raises wr_ok and keeps the earlier mapping.
- R7: A zero write to a valid counter raises wr_ok and removes every mapping that points at that counter. Mappings to other counters stay. The write also succeeds when nothing was mapped.
- R8: A lookup is combinational. lk_ctr is 0 on a miss, and lookups stay unchanged while no write is made.
- R9: Query counter 0 always reports cycles only, and query counter 2 always reports instructions only.
- R10: Any other queried counter reports q_cycles when event 0x00001 maps to it, and q_instret when event 0x00002 maps to it.
- R11: While wr_en is high, exactly one of wr_ok and wr_err is high in the same cycle. Both are low otherwise.
- R12: One counter may hold mappings for several events at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Selector write strobe |
| wr_ctr | input | CTR_W | Counter number being programmed |
| wr_sel | input | 20 | Event index written; zero means remove |
| wr_ok | output | 1 | Write accepted |
| wr_err | output | 1 | Write rejected |
| lk_evt | input | 20 | Event index to look up |
| lk_hit | output | 1 | Event is mapped |
| lk_ctr | output | CTR_W | Mapped counter, 0 on miss |
| q_ctr | input | CTR_W | Counter number queried |
| q_cycles | output | 1 | Queried counter counts cycles |
| q_instret | output | 1 | Queried counter counts instructions |

## Verification
Directed writes cover the following cases:
- counter numbers just below, inside and just above the valid range, each with zero and non-zero values;
- each whitelisted index, plus near misses that share a code or differ by one bit, which separates full-key matching from code-only matching;
- a repeated insert of the same event onto a different counter, which separates first-writer-wins from overwrite;
- a removal from a counter that holds two events, which shows that every matching entry is cleared and entries on other counters are kept.

A long random stream then mixes all of these while lookup and query ports sweep different values each cycle. It is compared with a reference map every cycle, and a reset in the middle of the run checks that the table empties.

// File: rtl/evmap_table.sv
module evmap_table #(
  parameter int NUM_PROG = 8,
  parameter int MAX_CTRS = 32,
  parameter int CTR_W    = $clog2(MAX_CTRS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTR_W-1:0] wr_ctr,
  input  logic [19:0]      wr_sel,
  output logic             wr_ok,
  output logic             wr_err,
  input  logic [19:0]      lk_evt,
  output logic             lk_hit,
  output logic [CTR_W-1:0] lk_ctr,
  input  logic [CTR_W-1:0] q_ctr,
  output logic             q_cycles,
  output logic             q_instret
);
  localparam int NSLOT = 5;
  localparam bit PROG_OK = NUM_PROG <= MAX_CTRS - 3;
  localparam logic [MAX_CTRS-1:0] AVAIL =
    PROG_OK ? MAX_CTRS'(((64'd1 << NUM_PROG) - 64'd1) << 3) : '0;

  function automatic logic [3:0] slot_of(input logic [19:0] e);
    case (e)
      20'h00001: return 4'b1000;
      20'h00002: return 4'b1001;
      20'h10019: return 4'b1010;
      20'h1001B: return 4'b1011;
      20'h10021: return 4'b1100;
      default:   return 4'b0000;
    endcase
  endfunction

  logic [NSLOT-1:0] ent_v;
  logic [CTR_W-1:0] ent_ctr [NSLOT];

  logic [3:0] wr_slot, lk_slot;
  logic       ctr_ok, wr_zero, wr_mapped, ins;

  assign wr_slot   = slot_of(wr_sel);
  assign lk_slot   = slot_of(lk_evt);
  assign ctr_ok    = AVAIL[wr_ctr];
  assign wr_zero   = wr_sel == '0;
  assign wr_mapped = wr_slot[3] && ent_v[wr_slot[2:0]];

  assign wr_err = wr_en && (!ctr_ok || (!wr_zero && !wr_slot[3]));
  assign wr_ok  = wr_en && !wr_err;
  assign ins    = wr_ok && !wr_zero && !wr_mapped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_v <= '0;
    end else begin
      for (int i = 0; i < NSLOT; i++) begin
        if (wr_ok && wr_zero && ent_v[i] && ent_ctr[i] == wr_ctr)
          ent_v[i] <= 1'b0;
        if (ins && wr_slot[2:0] == 3'(i)) begin
          ent_v[i]   <= 1'b1;
          ent_ctr[i] <= wr_ctr;
        end
      end
    end
  end

  assign lk_hit = lk_slot[3] && ent_v[lk_slot[2:0]];
  assign lk_ctr = lk_hit ? ent_ctr[lk_slot[2:0]] : '0;

  assign q_cycles  = (q_ctr == '0) || (ent_v[0] && ent_ctr[0] == q_ctr);
  assign q_instret = (q_ctr == CTR_W'(2)) || (ent_v[1] && ent_ctr[1] == q_ctr);
endmodule

// File: rtl/evmap_table_chk.sv
module evmap_table_chk #(
  parameter int NUM_PROG = 8,
  parameter int MAX_CTRS = 32,
  parameter int CTR_W    = $clog2(MAX_CTRS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [CTR_W-1:0] wr_ctr,
  input logic [19:0]      wr_sel,
  input logic             wr_ok,
  input logic             wr_err,
  input logic [19:0]      lk_evt,
  input logic             lk_hit,
  input logic [CTR_W-1:0] lk_ctr,
  input logic [CTR_W-1:0] q_ctr,
  input logic             q_cycles,
  input logic             q_instret
);
  localparam int LIM = (NUM_PROG <= MAX_CTRS - 3) ? 3 + NUM_PROG : 3;

  // R11
  wr_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $countones({wr_ok, wr_err}) == 1);

  // R11
  idle_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> !wr_ok && !wr_err);

  // R4
  bad_ctr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && ({1'b0, wr_ctr} < (CTR_W+1)'(3) || {1'b0, wr_ctr} >= (CTR_W+1)'(LIM))
    |-> wr_err);

  // R4
  hit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> {1'b0, lk_ctr} >= (CTR_W+1)'(3) && {1'b0, lk_ctr} < (CTR_W+1)'(LIM));

  // R9
  fixed_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_ctr == '0 |-> q_cycles && !q_instret);

  // R9
  fixed_ins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_ctr == CTR_W'(2) |-> q_instret && !q_cycles);

  // R5
  insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok && wr_sel != '0 && lk_evt == wr_sel && !lk_hit
    |=> (lk_evt != $past(lk_evt)) || (lk_hit && lk_ctr == $past(wr_ctr)));

  // R6
  keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && lk_hit && lk_evt == wr_sel
    |=> (lk_evt != $past(lk_evt)) || (lk_hit && lk_ctr == $past(lk_ctr)));
endmodule

bind evmap_table evmap_table_chk #(
  .NUM_PROG(NUM_PROG), .MAX_CTRS(MAX_CTRS), .CTR_W(CTR_W)
) chk_i (.*);

// File: tb/evmap_table_tb_top.sv
module evmap_table_tb_top;
  localparam int NUM_PROG = 8;
  localparam int CTR_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [CTR_W-1:0] wr_ctr = '0;
  logic [19:0] wr_sel = '0;
  logic wr_ok, wr_err, lk_hit, q_cycles, q_instret;
  logic [19:0] lk_evt = '0;
  logic [CTR_W-1:0] lk_ctr;
  logic [CTR_W-1:0] q_ctr = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit mv[5];
  int mc[5];

  always #4 clk = ~clk;

  evmap_table #(.NUM_PROG(NUM_PROG)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ctr(wr_ctr), .wr_sel(wr_sel),
    .wr_ok(wr_ok), .wr_err(wr_err), .lk_evt(lk_evt), .lk_hit(lk_hit),
    .lk_ctr(lk_ctr), .q_ctr(q_ctr), .q_cycles(q_cycles), .q_instret(q_instret)
  );

  function automatic int slot(int e);
    case (e)
      'h00001: return 0;
      'h00002: return 1;
      'h10019: return 2;
      'h1001B: return 3;
      'h10021: return 4;
      default: return -1;
    endcase
  endfunction

  function automatic int pick_evt(int k);
    case (k)
      0: return 0;
      1: return 'h00001;
      2: return 'h00002;
      3: return 'h10019;
      4: return 'h1001B;
      5: return 'h10021;
      6: return 'h00019;
      default: return 'h12345;
    endcase
  endfunction

  task automatic chk(bit good, string tag, string what, int act, int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 5; i++) mv[i] = 0;
  endtask

  // Drive one cycle, compare mid-cycle, then advance the model with the edge.
  task automatic step(bit we, int ctr, int sel, int lk, int q, string tag);
    bit valid, e_ok, e_err, e_hit, e_cyc, e_ins;
    int s, ls, e_ctr;
    wr_en = we; wr_ctr = CTR_W'(ctr); wr_sel = 20'(sel);
    lk_evt = 20'(lk); q_ctr = CTR_W'(q);
    #3;
    valid = ctr >= 3 && ctr < 3 + NUM_PROG;
    s = slot(sel);
    e_ok = 0; e_err = 0;
    if (we) begin
      if (!valid || (sel != 0 && s < 0)) e_err = 1;
      else e_ok = 1;
    end
    ls = slot(lk);
    e_hit = ls >= 0 && mv[ls];
    e_ctr = e_hit ? mc[ls] : 0;
    e_cyc = q == 0 || (mv[0] && mc[0] == q);
    e_ins = q == 2 || (mv[1] && mc[1] == q);
    chk(wr_ok == e_ok, tag, "wr_ok", wr_ok, e_ok);
    chk(wr_err == e_err, tag, "wr_err", wr_err, e_err);
    chk(lk_hit == e_hit, tag, "lk_hit", lk_hit, e_hit);
    chk(int'(lk_ctr) == e_ctr, tag, "lk_ctr", lk_ctr, e_ctr);
    chk(q_cycles == e_cyc, tag, "q_cycles", q_cycles, e_cyc);
    chk(q_instret == e_ins, tag, "q_instret", q_instret, e_ins);
    @(posedge clk);
    if (e_ok) begin
      if (sel == 0) begin
        for (int i = 0; i < 5; i++) if (mv[i] && mc[i] == ctr) mv[i] = 0;
      end else if (!mv[s]) begin
        mv[s] = 1; mc[s] = ctr;
      end
    end
    #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state, R9 fixed counters
    for (int k = 1; k < 6; k++) step(0, 3, 0, pick_evt(k), 0, "R1");
    step(0, 0, 0, 1, 2, "R9");
    step(0, 0, 0, 2, 5, "R10");

    // R4 counter range, including zero writes
    step(1, 2, 'h00001, 1, 0, "R4");
    step(1, 11, 'h00001, 1, 0, "R4");
    step(1, 31, 'h00002, 2, 0, "R4");
    step(1, 0, 0, 1, 0, "R4");

    // R5 insert, R10 query
    step(1, 3, 'h00001, 1, 3, "R5");
    step(0, 0, 0, 1, 3, "R10");
    // R6 first writer wins
    step(1, 4, 'h00001, 1, 4, "R6");
    step(0, 0, 0, 1, 4, "R6");
    step(1, 4, 'h00002, 2, 4, "R5");
    step(0, 0, 0, 2, 4, "R10");

    // R2 full 20-bit key, R3 whitelist
    step(1, 5, 'h00019, 'h00019, 5, "R2");
    step(1, 5, 'h12345, 'h10019, 5, "R3");
    step(1, 5, 'h10020, 'h10019, 5, "R3");
    step(1, 5, 'h10019, 'h10019, 5, "R5");
    // R12 two events on one counter
    step(1, 5, 'h1001B, 'h1001B, 5, "R12");
    step(1, 10, 'h10021, 'h10019, 10, "R5");
    step(0, 0, 0, 'h1001B, 0, "R12");
    step(0, 0, 0, 'h10021, 0, "R8");

    // R7 removal
    step(1, 5, 0, 'h10019, 5, "R7");
    step(0, 0, 0, 'h10019, 5, "R7");
    step(0, 0, 0, 'h1001B, 3, "R7");
    step(0, 0, 0, 'h10021, 3, "R7");
    step(1, 6, 0, 1, 3, "R7");
    step(1, 2, 0, 2, 4, "R4");
    step(0, 0, 0, 2, 4, "R4");
    step(1, 7, 'h10019, 'h10019, 7, "R5");
    step(0, 0, 0, 'h10019, 7, "R5");

    // Random mix, R8 stability covered by the reference map
    for (int n = 0; n < 400; n++) begin
      int c, q;
      c = $urandom_range(0, 12);
      if (c == 12) c = 31;
      q = $urandom_range(0, 11);
      step($urandom_range(0, 3) != 0, c, pick_evt($urandom_range(0, 7)),
           pick_evt($urandom_range(1, 7)), q, "R8");
    end

    // R1 reset mid-run
    rst_n = 1'b0;
    @(posedge clk);
    #1 rst_n = 1'b1;
    model_clear();
    for (int k = 1; k < 6; k++) step(0, 3, 0, pick_evt(k), k + 2, "R1");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule